// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Pacer

This block paces the periodic refresh commands of a DRAM controller. A down-counter, clocked by the controller clock, measures the average refresh spacing. The spacing is 7.8 µs when the device case is in its normal range (-40 °C to 85 °C). It halves to 3.9 µs in the extended range (above 85 °C up to 105 °C). The two spacings come from a retention window of 64 ms or 32 ms, in which 8192 refreshes must be issued. Each expired interval adds one owed refresh to a credit counter.

A request line tells the command arbiter that at least one refresh is owed. The arbiter issues a refresh only when all banks are idle, and it may hold refreshes back while it is busy. Each grant pays off one owed refresh. At most eight refreshes may be owed at a time. When eight are owed, an urgent flag tells the arbiter to stop postponing.

The interval lengths in cycles are worked out at elaboration from the clock period in picoseconds, rounded down. A change of the temperature flag is picked up only when the counter reloads, so an interval that is already running is never cut short or stretched.

Top module: `rfsh_pacer`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ref_req_o` and `ref_urgent_o` are low.
- R2: In the normal range the interval is floor(NORM_REFI_PS / CLK_PERIOD_PS) cycles. This is 975 with the defaults (8000 ps clock, 7 800 000 ps spacing). The first interval after reset ends 975 rising edges after reset is released.
- R3: While `temp_hot_i` is high at a reload, the next interval is floor(HOT_REFI_PS / CLK_PERIOD_PS) cycles. This is 487 with the defaults (3 900 000 ps spacing).
- R4: `temp_hot_i` is sampled only on the cycle the interval counter expires and reloads. A change during an interval leaves that interval's length unchanged.
- R5: Each expired interval adds one owed refresh. `ref_req_o` is high exactly while the owed count is non-zero.
- R6: The owed count saturates at MAX_POSTPONE (8). `ref_urgent_o` rises on the edge at which the count reaches 8. An interval that expires while the count is already 8 is dropped.
- R7: Once high, `ref_urgent_o` stays high until a grant is accepted, and it goes low on that grant.
- R8: A grant (`ref_gnt_i` high while `ref_req_o` is high) lowers the owed count by one. A grant while nothing is owed is ignored, and the count never goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_hot_i | input | 1 | High when the case temperature is in the extended range |
| ref_gnt_i | input | 1 | Arbiter has issued one refresh this cycle |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | The postponement limit has been reached |

## Verification
On every cycle, the assertions check four things. The interval counter steps down by one or reloads to one of the two lengths, chosen by the flag seen at expiry. The owed count stays between zero and eight and moves by at most one per cycle. The urgent flag rises at the limit and holds until a grant. Whether the interval lengths equal the rounded-down values, and whether a temperature change lands on the correct interval, can only be shown by the bench's timed scenarios. The same holds for postponing and catching up: only a scenario can show that exactly eight grants clear the backlog after saturation.

// File: rtl/rfsh_pkg.sv
// Shared helpers for the refresh pacer.
// Assumes all time quantities are integer picoseconds.
package rfsh_pkg;

    // Number of whole clock cycles that fit into a spacing (rounded down).
    function automatic int unsigned spacing_to_cycles(input int unsigned spacing_ps,
                                                      input int unsigned period_ps);
        return spacing_ps / period_ps;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Interval timer: counts down one refresh interval and pulses tick_o on
// its last cycle, then reloads. The length of the next interval is chosen
// from temp_hot_i on that reload cycle only.
// Assumes NORM_CYC >= HOT_CYC >= 2.
module rfsh_interval_timer #(
    parameter int unsigned NORM_CYC = 975,
    parameter int unsigned HOT_CYC  = 487
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (NORM_CYC > 2) ? $clog2(NORM_CYC) : 1;
    localparam logic [CNT_W-1:0] NORM_LD = CNT_W'(NORM_CYC - 1);
    localparam logic [CNT_W-1:0] HOT_LD  = CNT_W'(HOT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: the counter has reached its last cycle.
    assign tick_o = (cnt_q == '0);

    // Count down; on expiry reload the length chosen by the temperature flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= NORM_LD;
        else if (tick_o)
            cnt_q <= temp_hot_i ? HOT_LD : NORM_LD;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= NORM_LD);                                                   // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));                   // R2
    AST_RELOAD_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && temp_hot_i) |=> (cnt_q == HOT_LD));                // R3
    AST_RELOAD_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && !temp_hot_i) |=> (cnt_q == NORM_LD));              // R4
endmodule

// File: rtl/rfsh_credit_ctr.sv
// Owed-refresh counter: adds one per expired interval, removes one per
// accepted grant, saturates at MAX_PEND and flags urgency at the limit.
// Assumes tick_i is a one-cycle pulse and MAX_PEND >= 1.
module rfsh_credit_ctr #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic gnt_i,
    output logic req_o,
    output logic urgent_o
);
    localparam int unsigned PEND_W = $clog2(MAX_PEND + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(MAX_PEND);

    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] pend_nxt;
    logic              urg_q;
    logic              gnt_acc;

    // A grant counts only while something is owed.
    assign gnt_acc  = gnt_i && (pend_q != '0);
    assign req_o    = (pend_q != '0);
    assign urgent_o = urg_q;

    // Next owed count: add on tick, remove on grant, saturate at the limit.
    always_comb begin
        pend_nxt = pend_q;
        unique case ({tick_i, gnt_acc})
            2'b10:   if (pend_q != PEND_MAX) pend_nxt = pend_q + 1'b1;
            2'b01:   pend_nxt = pend_q - 1'b1;
            default: pend_nxt = pend_q;
        endcase
    end

    // Register the owed count.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // Urgent flag: set when the limit is reached, cleared by an accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                   urg_q <= 1'b0;
        else if (gnt_acc)             urg_q <= 1'b0;
        else if (pend_nxt == PEND_MAX) urg_q <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_MAX);                                                 // R6
    AST_URGENT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !gnt_acc && (pend_q == PEND_MAX - 1'b1)) |=> urgent_o);   // R6
    AST_URGENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_o && !gnt_i) |=> urgent_o);                                  // R7
    AST_URGENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_o && gnt_i) |=> !urgent_o);                                  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q == '0) && !tick_i) |=> (pend_q == '0));                     // R8
    AST_GRANT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_acc && !tick_i) |=> (pend_q == $past(pend_q) - 1'b1));          // R8
endmodule

// File: rtl/rfsh_pacer.sv
// Refresh pacer top: derives both interval lengths from the clock period,
// runs the interval timer and keeps the owed-refresh credit.
// Assumes CLK_PERIOD_PS is well below HOT_REFI_PS.
module rfsh_pacer #(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned NORM_REFI_PS  = 7_800_000,
    parameter int unsigned HOT_REFI_PS   = 3_900_000,
    parameter int unsigned MAX_POSTPONE  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot_i,
    input  logic ref_gnt_i,
    output logic ref_req_o,
    output logic ref_urgent_o
);
    import rfsh_pkg::*;

    localparam int unsigned NORM_CYC = spacing_to_cycles(NORM_REFI_PS, CLK_PERIOD_PS);
    localparam int unsigned HOT_CYC  = spacing_to_cycles(HOT_REFI_PS, CLK_PERIOD_PS);

    logic tick;

    rfsh_interval_timer #(
        .NORM_CYC (NORM_CYC),
        .HOT_CYC  (HOT_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_hot_i (temp_hot_i),
        .tick_o     (tick)
    );

    rfsh_credit_ctr #(
        .MAX_PEND (MAX_POSTPONE)
    ) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .gnt_i    (ref_gnt_i),
        .req_o    (ref_req_o),
        .urgent_o (ref_urgent_o)
    );

    AST_URGENT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent_o |-> ref_req_o);                                         // R6
endmodule

// File: tb/rfsh_pacer_bench.sv
`timescale 1ns/1ps
module rfsh_pacer_bench;
    localparam int unsigned NORM = 975;
    localparam int unsigned HOT  = 487;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_hot = 1'b0;
    logic gnt = 1'b0;
    logic req;
    logic urgent;
    int unsigned ec;
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    rfsh_pacer u_rfsh_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_hot_i   (temp_hot),
        .ref_gnt_i    (gnt),
        .ref_req_o    (req),
        .ref_urgent_o (urgent)
    );

    // Edges counted since reset release.
    always @(posedge clk) begin
        if (!rst_n) ec <= 0;
        else        ec <= ec + 1;
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wait_ec(input int unsigned target);
        while (ec < target) @(negedge clk);
    endtask

    task automatic grant_once();
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
    endtask

    task automatic wait_rise(output int unsigned t);
        while (!req) @(negedge clk);
        t = ec;
    endtask

    int unsigned last_tick;

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 req in reset", int'(req), 0);
        chk("R1 urgent in reset", int'(urgent), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after reset", int'(req), 0);
    endtask

    task automatic t_first_interval();
        wait_ec(NORM - 1);
        chk("R2 no request before first expiry", int'(req), 0);
        wait_ec(NORM);
        chk("R2 request at first expiry", int'(req), 1);
        chk("R5 request after one expiry", int'(req), 1);
        last_tick = ec;
    endtask

    task automatic gap_check(input string rq, input int unsigned exp_gap);
        int unsigned t;
        grant_once();
        chk({rq, " request cleared by grant"}, int'(req), 0);
        wait_rise(t);
        chk(rq, int'(t - last_tick), int'(exp_gap));
        last_tick = t;
    endtask

    task automatic t_temperature();
        gap_check("R2 normal gap", NORM);
        temp_hot = 1'b1;                 // after a reload: current interval stays normal
        gap_check("R4 hot mid-interval keeps length", NORM);
        gap_check("R3 hot gap", HOT);
        gap_check("R3 hot gap again", HOT);
        temp_hot = 1'b0;
        gap_check("R4 cool mid-interval keeps length", HOT);
        gap_check("R2 normal gap restored", NORM);
    endtask

    task automatic t_postpone();
        int unsigned t0;
        t0 = last_tick;                  // one refresh owed now
        wait_ec(t0 + 6 * NORM);
        chk("R6 urgent low at seven owed", int'(urgent), 0);
        wait_ec(t0 + 7 * NORM);
        chk("R6 urgent high at eight owed", int'(urgent), 1);
        wait_ec(t0 + 8 * NORM);
        chk("R7 urgent held without grant", int'(urgent), 1);
        @(negedge clk);
        grant_once();
        chk("R7 urgent cleared by grant", int'(urgent), 0);
        for (int i = 0; i < 6; i++) grant_once();
        chk("R6 one still owed after seven grants", int'(req), 1);
        grant_once();
        chk("R6 saturated backlog cleared by eight grants", int'(req), 0);
        last_tick = t0 + 8 * NORM;
    endtask

    task automatic t_underflow();
        grant_once();
        chk("R8 grant with nothing owed", int'(req), 0);
        wait_ec(last_tick + NORM);
        chk("R8 one owed after next expiry", int'(req), 1);
        grant_once();
        chk("R8 single grant clears it", int'(req), 0);
    endtask

    initial begin
        t_reset();
        t_first_interval();
        t_temperature();
        t_postpone();
        t_underflow();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule